// File: doc/BRIEF.md
# Block Adaptive I/Q Quantizer with Variance Normalisation

This block compresses complex radar echo samples. Signed in-phase and quadrature samples come in as pairs on a valid/ready stream. They are gathered into fixed-length blocks. While a block is written into one half of a two-bank sample store, the block computes its mean energy per complex sample. At the end of the block, that energy is turned into a variance segment index. A small computed table maps the index to a scale factor that brings the block's samples to unit standard deviation. The scaled I and Q magnitudes then go through a single normalised threshold ladder for the selected code width, and the block emits sign-magnitude codes.

The block emits its codes on a second valid/ready stream, one I/Q code pair per input pair. Each beat carries the block's variance index, so a decoder can rebuild the reconstruction levels. Flags mark the first and last code of each block.

Back-pressure rules:
- An input pair is taken on a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` falls only when both banks hold blocks that are not yet fully emitted.
- An output beat is taken when `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered beat is held unchanged.
- The configuration pins are plain levels, sampled once per block.

Top module: `bq_block_quantizer`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Block length L is 128, 256 or 512 for `cfg_len_sel` = 0, 1, or 2/3. All three configuration pins are captured with the first pair of a block. Changes while a block is being filled have no effect on that block. `out_first` is 1 on code 0 of a block and `out_last` is 1 on code L-1.
- R3: With E = floor(sum(I*I+Q*Q)/L) over the block, the index is min(E >> (2*IN_W-8-f), S-1). Here f = `cfg_seg_fine`, and S = 128 when f = 0 or S = 256 when f = 1.
- R4: The scale is s = isqrt(floor(2^(2F) / ((2*idx+1) * 2^(2*IN_W-10-f)))), where F = IN_W+6 and isqrt is the integer square root.
- R5: With p = |x|*s for a sample x, the level is min(floor(p / (T*2^(F-10))), 2^(B-1)-1). The code width B is 2, 3, 4 or 6 for `cfg_code_sel` 0..3, and 8 for 4..7. T is 1020, 600, 343, 107 or 32 for B = 2, 3, 4, 6 or 8.
- R6: A code has bit B-1 set exactly when the sample is negative. Bits B-2:0 hold the level, and bits 7:B are 0. I and Q are coded separately with the block's one scale factor.
- R7: `out_vidx` carries the block's index on every code of that block.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and all output fields stay unchanged.
- R9: `in_ready` stays 1 while one bank is free, so block N+1 is accepted while block N is being emitted. It is 0 only when both banks hold unfinished blocks.
- R10: Codes come out in the order the pairs went in, blocks in order, and never before their pair was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_sel | input | 2 | Block length select |
| cfg_code_sel | input | 3 | Code width select |
| cfg_seg_fine | input | 1 | 1: 256 variance segments, 0: 128 |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with valid |
| in_i | input | IN_W | Signed in-phase sample |
| in_q | input | IN_W | Signed quadrature sample |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_code_i | output | 8 | In-phase code |
| out_code_q | output | 8 | Quadrature code |
| out_vidx | output | 8 | Variance index of the block |
| out_first | output | 1 | First code of a block |
| out_last | output | 1 | Last code of a block |

## Verification
Two functions can fall in the same cycle. One is the write side accepting the last pair of block N+1, which computes its index and marks its bank full. The other is the read side emitting the last code of block N and switching banks. Back-to-back blocks under steady and patterned `out_ready` provoke this overlap. It is judged by a code-by-code comparison against a model of the arithmetic and by confirming that `in_ready` never drops while a bank is free. A stalled output with both banks filled checks the opposite edge: the input must stall, and every code must still come out intact.

// File: rtl/bq_pkg.sv
package bq_pkg;
  localparam int CODE_W      = 8;
  localparam int IDX_W       = 8;
  localparam int SCL_W       = 12;
  localparam int LEN_LOG_MAX = 9;
  localparam int ROM_DEPTH   = 384;

  typedef struct packed {
    logic [1:0] len_sel;
    logic [2:0] code_sel;
    logic       fine;
  } bq_cfg_t;

  function automatic int len_log(logic [1:0] s);
    return (s == 2'd0) ? 7 : (s == 2'd1) ? 8 : 9;
  endfunction

  function automatic int code_bits(logic [2:0] c);
    case (c)
      3'd0: return 2;
      3'd1: return 3;
      3'd2: return 4;
      3'd3: return 6;
      default: return 8;
    endcase
  endfunction

  // uniform step of the unit-variance ladder, in units of 2^-10
  function automatic int step_q10(logic [2:0] c);
    case (c)
      3'd0: return 1020;
      3'd1: return 600;
      3'd2: return 343;
      3'd3: return 107;
      default: return 32;
    endcase
  endfunction

  function automatic longint isqrt(longint v);
    longint r;
    r = 0;
    for (int b = 23; b >= 0; b--) begin
      longint t;
      t = r | (longint'(1) << b);
      if (t * t <= v) r = t;
    end
    return r;
  endfunction

  // entry g: g < 128 coarse segment g, else fine segment g-128
  function automatic longint scale_entry(int in_w, int g);
    int fine;
    int idx;
    longint den;
    longint num;
    fine = (g >= 128) ? 1 : 0;
    idx  = g - 128 * fine;
    den  = longint'(2 * idx + 1) << (2 * in_w - 10 - fine);
    num  = longint'(1) << (2 * (in_w + 6));
    return isqrt(num / den);
  endfunction
endpackage

// File: rtl/bq_ingest.sv
module bq_ingest
  import bq_pkg::*;
#(
  parameter int IN_W = 8,
  localparam int CW = LEN_LOG_MAX,
  localparam int AW = 2 * IN_W + LEN_LOG_MAX
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  input  bq_cfg_t                cfg_in,
  input  logic [1:0]             bank_full,
  output logic                   in_ready,
  output logic                   wr_en,
  output logic [CW:0]            wr_addr,
  output logic [2*IN_W-1:0]      wr_data,
  output logic                   blk_done,
  output logic                   blk_bank,
  output logic [IDX_W-1:0]       blk_idx,
  output bq_cfg_t                blk_cfg
);
  logic          wb;
  logic [CW-1:0] wcnt;
  logic [AW-1:0] acc;
  bq_cfg_t       held;
  bq_cfg_t       eff;
  logic [3:0]    llog;
  logic signed [2*IN_W-1:0] pi, pq;
  logic [AW-1:0] acc_nxt, energy, seg;
  logic [IDX_W-1:0] smax;
  logic          last, fire;

  assign eff  = (wcnt == '0) ? cfg_in : held;
  assign llog = 4'(len_log(eff.len_sel));
  assign pi   = in_i * in_i;
  assign pq   = in_q * in_q;
  assign acc_nxt = acc + AW'($unsigned(pi)) + AW'($unsigned(pq));
  assign energy  = acc_nxt >> llog;
  assign seg     = energy >> (2 * IN_W - 8 - int'(eff.fine));
  assign smax    = eff.fine ? IDX_W'(255) : IDX_W'(127);
  assign last    = (wcnt == CW'((1 << llog) - 1));

  assign in_ready = !bank_full[wb];
  assign fire     = in_valid && in_ready;
  assign wr_en    = fire;
  assign wr_addr  = {wb, wcnt};
  assign wr_data  = {in_i, in_q};
  assign blk_done = fire && last;
  assign blk_bank = wb;
  assign blk_idx  = (seg > AW'(smax)) ? smax : seg[IDX_W-1:0];
  assign blk_cfg  = eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb   <= 1'b0;
      wcnt <= '0;
      acc  <= '0;
      held <= '0;
    end else if (fire) begin
      if (wcnt == '0) held <= cfg_in;
      if (last) begin
        wcnt <= '0;
        acc  <= '0;
        wb   <= ~wb;
      end else begin
        wcnt <= wcnt + 1'b1;
        acc  <= acc_nxt;
      end
    end
  end
endmodule

// File: rtl/bq_scale_rom.sv
module bq_scale_rom
  import bq_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [8:0]       addr,
  output logic [SCL_W-1:0] scale
);
  logic [SCL_W-1:0] tbl [ROM_DEPTH];

  for (genvar g = 0; g < ROM_DEPTH; g++) begin : g_ent
    assign tbl[g] = SCL_W'(scale_entry(IN_W, g));
  end

  assign scale = (int'(addr) < ROM_DEPTH) ? tbl[addr] : '0;
endmodule

// File: rtl/bq_slicer.sv
module bq_slicer
  import bq_pkg::*;
#(
  parameter int IN_W = 8,
  localparam int FRAC = IN_W + 6,
  localparam int TW   = IN_W + SCL_W + 4,
  localparam int NK   = (1 << (CODE_W - 1)) - 1
) (
  input  logic signed [IN_W-1:0] sample,
  input  logic [SCL_W-1:0]       scale,
  input  logic [2:0]             code_sel,
  output logic [CODE_W-1:0]      code
);
  logic [IN_W-1:0] mag;
  logic [TW-1:0]   prod;
  logic [NK-1:0]   ge;
  logic [6:0]      lvl;
  logic [2:0]      sbit;
  int              maxm;
  int              step;

  assign mag  = sample[IN_W-1] ? (~sample + 1'b1) : sample;
  assign prod = TW'(mag) * TW'(scale);
  assign maxm = (1 << (code_bits(code_sel) - 1)) - 1;
  assign step = step_q10(code_sel);
  assign sbit = 3'(code_bits(code_sel) - 1);

  for (genvar k = 1; k <= NK; k++) begin : g_cmp
    assign ge[k-1] = (k <= maxm) && (prod >= (TW'(k * step) << (FRAC - 10)));
  end

  always_comb begin
    lvl = '0;
    for (int j = 0; j < NK; j++) lvl = lvl + 7'(ge[j]);
  end

  always_comb begin
    code       = CODE_W'(lvl);
    code[sbit] = sample[IN_W-1];
  end
endmodule

// File: rtl/bq_block_quantizer.sv
module bq_block_quantizer
  import bq_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_len_sel,
  input  logic [2:0]             cfg_code_sel,
  input  logic                   cfg_seg_fine,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_i,
  input  logic signed [IN_W-1:0] in_q,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [CODE_W-1:0]      out_code_i,
  output logic [CODE_W-1:0]      out_code_q,
  output logic [IDX_W-1:0]       out_vidx,
  output logic                   out_first,
  output logic                   out_last
);
  localparam int CW    = LEN_LOG_MAX;
  localparam int DEPTH = 2 << LEN_LOG_MAX;

  bq_cfg_t             cfg_now;
  logic                wr_en, blk_done, blk_bank;
  logic [CW:0]         wr_addr;
  logic [2*IN_W-1:0]   wr_data;
  logic [IDX_W-1:0]    blk_idx;
  bq_cfg_t             blk_cfg;

  logic [2*IN_W-1:0]   sbuf [DEPTH];
  logic [1:0]          full;
  logic [IDX_W-1:0]    bank_idx [2];
  bq_cfg_t             bank_cfg [2];
  logic                rb;
  logic [CW-1:0]       rcnt;

  logic [2*IN_W-1:0]   rword;
  bq_cfg_t             rcfg;
  logic [IDX_W-1:0]    ridx;
  logic [8:0]          rom_addr;
  logic [SCL_W-1:0]    scale;
  logic [CODE_W-1:0]   lane_code [2];
  logic                rlast, load;

  assign cfg_now = '{len_sel: cfg_len_sel, code_sel: cfg_code_sel, fine: cfg_seg_fine};

  bq_ingest #(.IN_W(IN_W)) i_ingest (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_i     (in_i),
    .in_q     (in_q),
    .cfg_in   (cfg_now),
    .bank_full(full),
    .in_ready (in_ready),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .blk_done (blk_done),
    .blk_bank (blk_bank),
    .blk_idx  (blk_idx),
    .blk_cfg  (blk_cfg)
  );

  always_ff @(posedge clk) begin
    if (wr_en) sbuf[wr_addr] <= wr_data;
    if (blk_done) begin
      bank_idx[blk_bank] <= blk_idx;
      bank_cfg[blk_bank] <= blk_cfg;
    end
  end

  assign rword    = sbuf[{rb, rcnt}];
  assign rcfg     = bank_cfg[rb];
  assign ridx     = bank_idx[rb];
  assign rom_addr = rcfg.fine ? (9'd128 + 9'(ridx)) : 9'(ridx);

  bq_scale_rom #(.IN_W(IN_W)) i_rom (
    .addr (rom_addr),
    .scale(scale)
  );

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    bq_slicer #(.IN_W(IN_W)) i_slicer (
      .sample  (ln == 0 ? rword[2*IN_W-1:IN_W] : rword[IN_W-1:0]),
      .scale   (scale),
      .code_sel(rcfg.code_sel),
      .code    (lane_code[ln])
    );
  end

  assign rlast = (rcnt == CW'((1 << len_log(rcfg.len_sel)) - 1));
  assign load  = full[rb] && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (blk_done && (blk_bank == 1'(b)))
          full[b] <= 1'b1;
        else if (load && rlast && (rb == 1'(b)))
          full[b] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      rb         <= 1'b0;
      rcnt       <= '0;
      out_code_i <= '0;
      out_code_q <= '0;
      out_vidx   <= '0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_code_i <= lane_code[0];
      out_code_q <= lane_code[1];
      out_vidx   <= ridx;
      out_first  <= (rcnt == '0);
      out_last   <= rlast;
      if (rlast) begin
        rcnt <= '0;
        rb   <= ~rb;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bq_chk.sv
module bq_chk
  import bq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code_i,
  input logic [CODE_W-1:0] out_code_q,
  input logic [IDX_W-1:0]  out_vidx,
  input logic              out_first,
  input logic              out_last
);
  logic [31:0]      in_cnt, out_cnt;
  logic             expect_first;
  logic [IDX_W-1:0] blk_vidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cnt       <= '0;
      out_cnt      <= '0;
      expect_first <= 1'b1;
      blk_vidx     <= '0;
    end else begin
      if (in_valid && in_ready) in_cnt <= in_cnt + 1;
      if (out_valid && out_ready) begin
        out_cnt      <= out_cnt + 1;
        expect_first <= out_last;
        if (out_first) blk_vidx <= out_vidx;
      end
    end
  end

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code_i) && $stable(out_code_q)
      && $stable(out_vidx) && $stable(out_first) && $stable(out_last));

  // R2
  first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_first == expect_first);

  // R7
  vidx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_first |-> out_vidx == blk_vidx);

  // R10
  causal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cnt < in_cnt);

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (in_cnt - out_cnt) > 32'd128);
endmodule

bind bq_block_quantizer bq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_code_i(out_code_i),
  .out_code_q(out_code_q),
  .out_vidx  (out_vidx),
  .out_first (out_first),
  .out_last  (out_last)
);

// File: tb/test_bq_block_quantizer.sv
`timescale 1ns/1ps
module test_bq_block_quantizer;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_len_sel = 2'd0;
  logic [2:0] cfg_code_sel = 3'd0;
  logic cfg_seg_fine = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [IW-1:0] in_i = '0;
  logic signed [IW-1:0] in_q = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_code_i, out_code_q, out_vidx;
  logic out_first, out_last;

  always #10 clk = ~clk;

  bq_block_quantizer #(.IN_W(IW)) i_bq_block_quantizer (
    .clk(clk), .rst_n(rst_n),
    .cfg_len_sel(cfg_len_sel), .cfg_code_sel(cfg_code_sel), .cfg_seg_fine(cfg_seg_fine),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_code_i(out_code_i), .out_code_q(out_code_q), .out_vidx(out_vidx),
    .out_first(out_first), .out_last(out_last)
  );

  int checks = 0;
  int errors = 0;
  int rmode = 0;
  int rcyc = 0;
  int stalls = 0;
  int chk_ptr = 0;

  int exp_ci[$], exp_cq[$], exp_ix[$], exp_f[$], exp_l[$];
  int got_ci[$], got_cq[$], got_ix[$], got_f[$], got_l[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // out_ready driver, updated just after the active edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      rcyc++;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = ((rcyc % 3) != 1) && ((rcyc % 7) != 0);
        default: out_ready = 1'b0;
      endcase
    end
  end

  // output monitor and R8 hold check
  bit hold_pend = 0;
  logic [7:0] h_ci, h_cq, h_ix;
  logic h_f, h_l;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        check(out_valid && out_code_i == h_ci && out_code_q == h_cq && out_vidx == h_ix
              && out_first == h_f && out_last == h_l, "R8", "held beat changed",
              {out_code_i, out_code_q}, {h_ci, h_cq});
        hold_pend = 0;
      end
      if (out_valid) begin
        if (out_ready) begin
          got_ci.push_back(out_code_i);
          got_cq.push_back(out_code_q);
          got_ix.push_back(out_vidx);
          got_f.push_back(out_first);
          got_l.push_back(out_last);
        end else begin
          hold_pend = 1;
          h_ci = out_code_i; h_cq = out_code_q; h_ix = out_vidx;
          h_f = out_first; h_l = out_last;
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    finish_sim();
  end

  function automatic int blen(int s); return s == 0 ? 128 : s == 1 ? 256 : 512; endfunction
  function automatic int blog(int s); return s == 0 ? 7 : s == 1 ? 8 : 9; endfunction
  function automatic int bwid(int w);
    return w == 0 ? 2 : w == 1 ? 3 : w == 2 ? 4 : w == 3 ? 6 : 8;
  endfunction
  function automatic int bstep(int w);
    return w == 0 ? 1020 : w == 1 ? 600 : w == 2 ? 343 : w == 3 ? 107 : 32;
  endfunction
  function automatic longint root(longint v);
    longint r = 0;
    while ((r + 1) * (r + 1) <= v) r++;
    return r;
  endfunction
  function automatic int model_code(int x, longint s, int w);
    int b = bwid(w);
    longint mag = x < 0 ? -x : x;
    longint t = longint'(bstep(w)) << (IW + 6 - 10);
    longint m = (mag * s) / t;
    longint mx = (1 << (b - 1)) - 1;
    if (m > mx) m = mx;
    return (x < 0 ? (1 << (b - 1)) : 0) | int'(m);
  endfunction

  // kind 0: spread pattern, 1: all zero, 2: most negative value
  task automatic send_block(input int lsel, input int wsel, input int fine,
                            input int amp, input int seed, input int kind, input int alt_at);
    int L = blen(lsel);
    int xi[512];
    int xq[512];
    longint sum = 0;
    longint e, seg, idx, s;
    int smax;
    for (int n = 0; n < L; n++) begin
      if (kind == 0) begin
        xi[n] = ((n * 37 + seed * 13 + (n * n) % 17) % (2 * amp + 1)) - amp;
        xq[n] = ((n * 53 + seed * 7 + (n * 3) % 11) % (2 * amp + 1)) - amp;
      end else if (kind == 1) begin
        xi[n] = 0; xq[n] = 0;
      end else begin
        xi[n] = -(1 << (IW - 1)); xq[n] = -(1 << (IW - 1));
      end
      sum += xi[n] * xi[n] + xq[n] * xq[n];
    end
    for (int n = 0; n < L; n++) begin
      @(negedge clk);
      if (n >= alt_at) begin
        cfg_len_sel = 2'(2 - (lsel == 2 ? 1 : 0));
        cfg_code_sel = 3'(4 - (wsel == 4 ? 2 : 0));
        cfg_seg_fine = ~1'(fine);
      end else begin
        cfg_len_sel = 2'(lsel); cfg_code_sel = 3'(wsel); cfg_seg_fine = 1'(fine);
      end
      in_valid = 1'b1;
      in_i = IW'(xi[n]);
      in_q = IW'(xq[n]);
      while (!in_ready) begin
        stalls++;
        @(negedge clk);
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    cfg_len_sel = 2'(lsel); cfg_code_sel = 3'(wsel); cfg_seg_fine = 1'(fine);
    e = sum >> blog(lsel);
    seg = e >> (2 * IW - 8 - fine);
    smax = fine ? 255 : 127;
    idx = seg > smax ? smax : seg;
    s = root((longint'(1) << (2 * (IW + 6))) / ((2 * idx + 1) << (2 * IW - 10 - fine)));
    for (int n = 0; n < L; n++) begin
      exp_ci.push_back(model_code(xi[n], s, wsel));
      exp_cq.push_back(model_code(xq[n], s, wsel));
      exp_ix.push_back(int'(idx));
      exp_f.push_back(n == 0);
      exp_l.push_back(n == L - 1);
    end
  endtask

  task automatic compare_out(input string tag);
    int waited = 0;
    while (got_ci.size() < exp_ci.size() && waited < 8000) begin
      @(negedge clk);
      waited++;
    end
    check(got_ci.size() == exp_ci.size(), "R10", {tag, " code count"},
          got_ci.size(), exp_ci.size());
    for (int k = chk_ptr; k < exp_ci.size() && k < got_ci.size(); k++) begin
      check(got_ci[k] == exp_ci[k] && got_cq[k] == exp_cq[k], "R5 R6 R10",
            $sformatf("%s codes at %0d (i,q packed)", tag, k),
            got_ci[k] * 256 + got_cq[k], exp_ci[k] * 256 + exp_cq[k]);
      check(got_ix[k] == exp_ix[k], "R3 R4 R7", $sformatf("%s index at %0d", tag, k),
            got_ix[k], exp_ix[k]);
      check(got_f[k] == exp_f[k] && got_l[k] == exp_l[k], "R2",
            $sformatf("%s first/last at %0d", tag, k),
            got_f[k] * 2 + got_l[k], exp_f[k] * 2 + exp_l[k]);
    end
    chk_ptr = exp_ci.size();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_basic();
    rmode = 0;
    send_block(0, 0, 0, 40, 1, 0, 9999);
    compare_out("basic width2 coarse");
  endtask

  task automatic t_widths();
    rmode = 1;
    send_block(0, 1, 1, 90, 2, 0, 9999);
    send_block(0, 2, 0, 20, 3, 0, 9999);
    send_block(0, 3, 1, 127, 4, 0, 9999);
    send_block(0, 7, 0, 60, 5, 0, 9999);
    compare_out("widths with backpressure R8");
  endtask

  task automatic t_lengths();
    rmode = 1;
    send_block(1, 4, 1, 70, 6, 0, 9999);
    send_block(2, 2, 0, 100, 7, 0, 9999);
    send_block(3, 1, 1, 10, 8, 0, 9999);
    compare_out("lengths R2");
  endtask

  task automatic t_extremes();
    rmode = 0;
    send_block(0, 0, 0, 0, 0, 2, 9999);
    compare_out("saturated");
    // R3: clamp to top coarse segment; R5: level clipped at 1, sign set
    check(got_ix[got_ix.size() - 1] == 127, "R3", "clamped index", got_ix[got_ix.size() - 1], 127);
    check(got_ci[got_ci.size() - 1] == 3, "R5", "clipped negative code", got_ci[got_ci.size() - 1], 3);
    send_block(0, 4, 1, 0, 0, 1, 9999);
    compare_out("zero");
    check(got_ix[got_ix.size() - 1] == 0, "R3", "zero-energy index", got_ix[got_ix.size() - 1], 0);
    check(got_cq[got_cq.size() - 1] == 0, "R6", "zero sample code", got_cq[got_cq.size() - 1], 0);
  endtask

  task automatic t_cfg_mid();
    rmode = 0;
    send_block(0, 0, 0, 50, 9, 0, 5);
    compare_out("R2 config change mid-block ignored");
  endtask

  task automatic t_overlap();
    rmode = 0;
    stalls = 0;
    send_block(0, 2, 1, 80, 10, 0, 9999);
    send_block(0, 3, 0, 30, 11, 0, 9999);
    check(stalls == 0, "R9", "input stalls during back-to-back blocks", stalls, 0);
    compare_out("overlap R9");
  endtask

  task automatic t_full();
    rmode = 2;
    send_block(0, 1, 0, 45, 12, 0, 9999);
    send_block(0, 4, 1, 115, 13, 0, 9999);
    @(negedge clk);
    check(in_ready == 1'b0, "R9", "in_ready with both banks occupied", in_ready, 0);
    rmode = 0;
    send_block(0, 0, 1, 25, 14, 0, 9999);
    compare_out("both banks full R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_widths();
    t_lengths();
    t_extremes();
    t_cfg_mid();
    t_overlap();
    t_full();
    repeat (5) @(negedge clk);
    finish_sim();
  end
endmodule